// File: doc/BRIEF.md
# Clock Alarm Change-Event Interrupt Register

This block sits next to a clock-monitor circuit and turns four alarm levels into host interrupts: primary reference lost, secondary reference lost, PLL in holdover, and PLL out of lock. Each level is first brought into the local clock domain. Every change of a level is then kept as a sticky cause bit, with one bit for the rising edge and one for the falling edge. The result is an 8-bit cause byte and one interrupt line that stays high while that byte is nonzero.

A host reaches the block through a byte-wide read-only bus with eight addresses. The host reads the cause byte to learn what happened, and that same read clears it. A status byte gives the present alarm levels. An identification byte reports which interrupt line is wired to the block, or reports that the clock hardware is absent. Read data appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `alarm_event_irq`

## Requirements
- R1: Cause bit layout: bit 0 primary loss rose, bit 1 primary loss fell, bit 2 secondary loss rose, bit 3 secondary loss fell, bit 4 holdover rose, bit 5 holdover fell, bit 6 unlock rose, bit 7 unlock fell. The alarm input bits are 0 primary loss, 1 secondary loss, 2 holdover and 3 unlock.
- R2: A cause bit, once set, stays set until the cause byte is read. A second edge on another signal adds its bit and keeps the earlier bits.
- R3: A read at offset 6 returns the cause byte as it stood before that clock edge and clears every cause bit on the same edge.
- R4: An edge that is detected on the same clock edge as a clearing read is kept. Its bit is set after the clear, and it appears on the next read of offset 6.
- R5: `irq` is high while any cause bit is set. It falls in the cycle after a clearing read that is not accompanied by a new edge.
- R6: A read at offset 2 returns the synchronized alarm levels in bits 7 to 4: bit 7 primary lost, bit 6 secondary lost, bit 5 holdover, bit 4 unlock. Bits 3 to 0 carry `aux_status`.
- R7: A read at offset 7 returns the interrupt line number in bits 3 to 0, or 0xF when the hardware is marked absent. Bits 7 to 4 read zero.
- R8: Reads at offsets 0, 1, 3, 4 and 5 return zero. A read at any offset other than 6 leaves the cause byte and `irq` unchanged.
- R9: An alarm input change made before clock edge k is recorded in the cause byte on edge k+2, after a two-flop synchronizer and an edge-detect stage. `irq` is still low after edge k+1.
- R10: While `rst_n` is low, the cause byte clears, `irq` is low and `rd_data` is zero. Alarm levels that are present during a reset of at least three cycles raise no edge when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_in | input | 4 | Asynchronous alarm levels: 0 primary loss, 1 secondary loss, 2 holdover, 3 unlock |
| aux_status | input | 4 | Unrelated status bits returned in the low nibble of offset 2 |
| rd_en | input | 1 | Read strobe, one access per cycle it is high |
| rd_addr | input | 3 | Byte offset in the register window |
| rd_data | output | 8 | Read data, registered on the edge that samples `rd_en` |
| irq | output | 1 | Level interrupt, high while the cause byte is nonzero |

## Verification
The one collision that matters is an alarm edge landing on the same clock edge as a host read of the cause byte. This is where the clear and the set of the cause register meet. The bench provokes it by changing an alarm input exactly two falling edges before it issues the read, so that the edge-detect output is active on the edge that performs the read. It then checks three things: the read returns only the earlier bits, `irq` stays high after the read, and the next read returns the new bit alone.

// File: rtl/alarm_evt_pkg.sv
// Shared constants for the clock alarm change-event block.
// Assumes a fixed set of four alarm signals whose cause-bit and
// status-bit positions are decoded by host software.
package alarm_evt_pkg;
    localparam int NUM_ALM     = 4;
    localparam int CAUSE_W     = 2 * NUM_ALM;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;

    // Host-visible offsets; software depends on these values.
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CAUSE  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_IRQID  = 3'd7;

    // Alarm input indices.
    localparam int ALM_PRI_LOS = 0;
    localparam int ALM_SEC_LOS = 1;
    localparam int ALM_HOLD    = 2;
    localparam int ALM_UNLOCK  = 3;

    // Nibble returned when the clock hardware is marked absent.
    localparam logic [3:0] IRQID_ABSENT = 4'hF;
endpackage

// File: rtl/alarm_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is a slow level, so bits need no mutual coherence.
// The flops carry no reset: they keep sampling while rst_n is low, so
// the level already seen at the last stage is valid when reset ends.
module alarm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the sampled levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        stg[0] <= din;
        for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/alarm_edge_cause.sv
// Edge detector and sticky cause register.
// For alarm i, cause bit 2i records a rising edge and bit 2i+1 records
// a falling edge. A clear request empties the register, but edges found
// in the same cycle are set after that clear, so no event is lost.
// Assumes lvl is already synchronized. During reset the previous-level
// register tracks lvl, so leaving reset raises no edge.
module alarm_edge_cause #(
    parameter int NUM = 4,
    localparam int CW = 2 * NUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] lvl,
    input  logic           clr,
    output logic [CW-1:0]  cause,
    output logic [CW-1:0]  set_vec
);
    logic [NUM-1:0] prev;

    // Remember last cycle's level; this runs in reset too, which seeds it.
    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    // Map each alarm's rise and fall onto its pair of cause bits.
    generate
        for (genvar i = 0; i < NUM; i++) begin : g_edge
            assign set_vec[2*i]   =  lvl[i] & ~prev[i];
            assign set_vec[2*i+1] = ~lvl[i] &  prev[i];
        end
    endgenerate

    // Sticky cause bits: clear on request, then merge this cycle's edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else begin
            cause <= (clr ? '0 : cause) | set_vec;
        end
    end

    // R1: every detected edge shows up in the cause register.
    p_edge_captured_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));

    // R2: without a clear, no bit that was set goes away.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cause & $past(cause)) == $past(cause)));

    // R3: a clear with no concurrent edge empties the register.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (cause == '0));

    // R4: a clear with concurrent edges leaves exactly those edges.
    p_edge_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && |set_vec) |=> (cause == $past(set_vec)));
endmodule

// File: rtl/alarm_reg_read.sv
// Byte-wide read port for the eight-offset register window.
// Decodes the offset, forms the read byte and registers it. It also
// raises the clear request for the cause register on a read of the
// cause offset. Read data holds its value between reads.
module alarm_reg_read
    import alarm_evt_pkg::*;
#(
    parameter logic [3:0] IRQ_NUM    = 4'hB,
    parameter bit         HW_PRESENT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [NUM_ALM-1:0] lvl,
    input  logic [3:0]         aux_status,
    output logic               cause_clr,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [3:0] IRQID_NIB = HW_PRESENT ? IRQ_NUM : IRQID_ABSENT;

    logic [3:0]        lvl_hi;
    logic [DATA_W-1:0] rd_mux;

    // Place alarm i at status bit 7-i, so primary loss lands at bit 7.
    always_comb begin
        for (int i = 0; i < NUM_ALM; i++) begin
            lvl_hi[NUM_ALM-1-i] = lvl[i];
        end
    end

    // Select the byte for the addressed offset; unused offsets give zero.
    always_comb begin
        unique case (rd_addr)
            OFS_STATUS: rd_mux = {lvl_hi, aux_status};
            OFS_CAUSE:  rd_mux = cause;
            OFS_IRQID:  rd_mux = {4'h0, IRQID_NIB};
            default:    rd_mux = '0;
        endcase
    end

    assign cause_clr = rd_en && (rd_addr == OFS_CAUSE);

    // Register the read byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    // R3: a cause read returns what the register held before the clear.
    p_cause_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cause_clr |=> (rd_data == $past(cause)));

    // R6: the status read carries the live levels, primary loss at bit 7.
    p_status_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_STATUS) |=>
            (rd_data[7] == $past(lvl[ALM_PRI_LOS]) &&
             rd_data[4] == $past(lvl[ALM_UNLOCK])));

    // R7: the upper nibble of the identification byte is always zero.
    p_irqid_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_IRQID) |=> (rd_data[7:4] == 4'h0));

    // R8: offsets outside the decoded three read as zero.
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFS_STATUS && rd_addr != OFS_CAUSE &&
         rd_addr != OFS_IRQID) |=> (rd_data == '0));
endmodule

// File: rtl/alarm_event_irq.sv
// Clock alarm change-event interrupt register (top level).
// Synchronizes four asynchronous alarm levels, records each rising and
// falling edge as a sticky cause bit, drives a level interrupt while
// any cause bit is set, and serves a byte-wide read window. A read of
// the cause byte clears it. Assumes rst_n is held low for at least
// SYNC_STAGES+1 cycles, so the synchronizer holds valid levels.
module alarm_event_irq
    import alarm_evt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] IRQ_NUM     = 4'hB,
    parameter bit         HW_PRESENT  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  alarm_in,
    input  logic [3:0]  aux_status,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        irq
);
    logic [NUM_ALM-1:0] lvl;
    logic [CAUSE_W-1:0] cause;
    logic [CAUSE_W-1:0] set_vec;
    logic               cause_clr;

    alarm_sync #(
        .WIDTH  (NUM_ALM),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .din  (alarm_in),
        .dout (lvl)
    );

    alarm_edge_cause #(
        .NUM (NUM_ALM)
    ) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .clr     (cause_clr),
        .cause   (cause),
        .set_vec (set_vec)
    );

    alarm_reg_read #(
        .IRQ_NUM    (IRQ_NUM),
        .HW_PRESENT (HW_PRESENT)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cause      (cause),
        .lvl        (lvl),
        .aux_status (aux_status),
        .cause_clr  (cause_clr),
        .rd_data    (rd_data)
    );

    // Interrupt is the OR of the registered cause bits (no extra delay).
    assign irq = |cause;

    // R5: a clearing read with no new edge drops the interrupt next cycle.
    p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr && set_vec == '0) |=> !irq);

    // R5: the interrupt only rises because an edge was detected.
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|set_vec));

    // R8: reads of other offsets never lower the interrupt.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cause_clr) |=> irq);
endmodule

// File: tb/alarm_event_irq_test.sv
// Scoreboard bench: read tasks push the expected byte, and a monitor
// pops and compares it on the falling edge after the read is sampled.
module alarm_event_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alarm_in = 4'b0000;
    logic [3:0] aux_status = 4'h5;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pend_q = 1'b0;

    always #5 clk = ~clk;

    alarm_event_irq #(
        .SYNC_STAGES (2),
        .IRQ_NUM     (4'hB),
        .HW_PRESENT  (1'b1)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_in   (alarm_in),
        .aux_status (aux_status),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Note which cycles carry a sampled read.
    always @(posedge clk) pend_q <= rd_en && rst_n;

    // Monitor: compare read data one falling edge after the sampling edge.
    always @(negedge clk) begin
        if (pend_q) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 8'h00, 8'hFF);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: one read, starting and ending on a falling edge.
    task automatic do_read(input logic [2:0] a, input logic [7:0] exp,
                           input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10: reset with holdover already high.
        alarm_in = 4'b0100;
        idle(5);
        check("R10 reset irq", {7'd0, irq}, 8'h00);
        check("R10 reset rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        idle(4);
        check("R10 no edge from reset levels", {7'd0, irq}, 8'h00);

        // R6, R7, R8: static reads.
        do_read(3'd2, 8'h25, "R6 status levels");
        do_read(3'd7, 8'h0B, "R7 irq id byte");
        do_read(3'd0, 8'h00, "R8 offset 0");
        do_read(3'd1, 8'h00, "R8 offset 1");
        do_read(3'd3, 8'h00, "R8 offset 3");
        do_read(3'd4, 8'h00, "R8 offset 4");
        do_read(3'd5, 8'h00, "R8 offset 5");

        // R9: primary loss rises; latency through sync and edge stage.
        alarm_in[0] = 1'b1;
        idle(2);
        check("R9 irq still low after edge k+1", {7'd0, irq}, 8'h00);
        idle(1);
        check("R9 R5 irq high after edge k+2", {7'd0, irq}, 8'h01);

        // R8: a status read does not clear the cause byte.
        do_read(3'd2, 8'hA5, "R6 R8 status with primary lost");
        check("R8 irq kept after status read", {7'd0, irq}, 8'h01);

        // R1, R3, R5: cause read returns bit 0, clears, and drops irq.
        do_read(3'd6, 8'h01, "R1 R3 primary rose");
        check("R5 irq low after clearing read", {7'd0, irq}, 8'h00);
        do_read(3'd6, 8'h00, "R3 cleared");

        // R1, R2: holdover falls and unlock rises, then primary falls.
        alarm_in[2] = 1'b0;
        alarm_in[3] = 1'b1;
        idle(3);
        alarm_in[0] = 1'b0;
        idle(3);
        do_read(3'd6, 8'h62, "R1 R2 sticky accumulation");

        // R1: secondary loss pulse gives both its bits.
        alarm_in[1] = 1'b1;
        idle(4);
        alarm_in[1] = 1'b0;
        idle(3);
        do_read(3'd6, 8'h0C, "R1 secondary rose and fell");

        // R4: unlock falls on the same edge as a clearing read.
        alarm_in[0] = 1'b1;
        idle(3);
        alarm_in[3] = 1'b0;
        idle(2);
        do_read(3'd6, 8'h01, "R4 read returns earlier bit only");
        check("R4 irq kept by concurrent edge", {7'd0, irq}, 8'h01);
        do_read(3'd6, 8'h80, "R4 concurrent edge kept");
        check("R5 irq low at end", {7'd0, irq}, 8'h00);

        idle(2);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end
endmodule